// File: doc/BRIEF.md
# Dual-Channel Edge Capture Unit

This block timestamps events on two asynchronous input pins against a shared free-running counter. Each channel brings its pin into the clock domain through a two-stage synchronizer. It then compares the synchronized level with the level from the cycle before to find the edge type that its mode selects. When that edge appears, the channel copies the counter value seen in that cycle into its own capture register and raises its event flag.

The counter comes in from outside and is only sampled here. Software-facing logic around the block supplies one control word that holds both mode fields, a per-channel interrupt enable and a per-channel write-one-to-clear strobe. It reads the captured values through a word-indexed read port. A single interrupt line is high while any enabled flag is set.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous reset, both capture registers read 0, both flags are 0 and the interrupt output is 0.
- R2: A pin change becomes visible after two synchronizer flops and one history flop. The capture register then holds the counter value that was present on the counter input during the third rising clock edge after the pin change, and the flag is 1 from that edge onward.
- R3: Channel n's mode is read from control bits [2n+1:2n], encoded as 0 = off, 1 = rising edge, 2 = falling edge, 3 = either edge.
- R4: In rising mode, a falling edge changes neither the capture register nor the flag.
- R5: In falling mode, a rising edge changes neither the capture register nor the flag, and a falling edge captures.
- R6: In either-edge mode, both a rising and a falling edge capture.
- R7: With mode 0 a channel ignores its pin: the capture register and the flag keep their values.
- R8: A new capture overwrites the capture register even while the flag is still 1, and the flag stays 1.
- R9: Bit n of the clear strobe, when 1 for one cycle, clears flag n only. A strobe of all zeros changes no flag.
- R10: If a capture and a clear of the same channel fall in the same cycle, the capture wins: the new value is stored and the flag ends at 1.
- R11: The interrupt output is 1 exactly when some channel has both its flag and its enable bit at 1.
- R12: The read port returns channel 0's capture register at word address 0 and channel 1's at word address 1, without a clock delay.
- R13: The channels are independent: edges on both pins in the same cycle are captured by both channels with the same counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Shared free-running counter value |
| pin_i | input | NCH | Asynchronous event pins, one per channel |
| ctrl_i | input | 2*NCH | Packed mode fields, two bits per channel |
| clr_i | input | NCH | Write-one-to-clear strobe for the flags |
| irq_en_i | input | NCH | Per-channel interrupt enable |
| rd_addr_i | input | AW | Word address of the capture register to read |
| rd_data_o | output | CNT_W | Selected capture register |
| flag_o | output | NCH | Per-channel event flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A detected edge that sets a flag and a software clear of that same flag can both land in one clock cycle. The bench provokes this by changing a pin and then raising the channel's clear strobe two cycles later. That puts the clear in the very cycle in which the edge leaves the synchronizer. The outcome is judged correct only if the new counter value is stored and the flag reads 1 afterwards. A second overlap, edges on both pins in the same cycle, is judged by reading both capture registers through the read port and expecting one identical timestamp in each.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    localparam int MODE_W = 2;

    // True when the level pair (current, previous) is an edge the mode accepts.
    function automatic logic mode_fires(input cap_mode_e mode, input logic now_lvl,
                                        input logic old_lvl);
        logic rise;
        logic fall;
        rise = now_lvl & ~old_lvl;
        fall = ~now_lvl & old_lvl;
        case (mode)
            CAP_RISE: mode_fires = rise;
            CAP_FALL: mode_fires = fall;
            CAP_BOTH: mode_fires = rise | fall;
            default:  mode_fires = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ecu_edge_detect.sv
module ecu_edge_detect
    import ecu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  cap_mode_e mode_i,
    output logic      hit_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // History flop keeps tracking while disabled, so enabling never fires on stale state.
    assign hit_o = mode_fires(mode_i, sync_q[SYNC_STAGES-1], prev_q);

endmodule

// File: rtl/ecu_chan_reg.sv
module ecu_chan_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (hit_i) begin
                cap_o  <= cnt_i;
                flag_o <= 1'b1;
            end else if (clr_i) begin
                flag_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic [NCH-1:0]        pin_i,
    input  logic [MODE_W*NCH-1:0] ctrl_i,
    input  logic [NCH-1:0]        clr_i,
    input  logic [NCH-1:0]        irq_en_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [CNT_W-1:0]      rd_data_o,
    output logic [NCH-1:0]        flag_o,
    output logic                  irq_o
);
    logic [NCH-1:0]            edge_hit;
    logic [NCH-1:0][CNT_W-1:0] cap_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cap_mode_e mode;
        assign mode = cap_mode_e'(ctrl_i[MODE_W*g +: MODE_W]);

        ecu_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[g]),
            .mode_i (mode),
            .hit_o  (edge_hit[g])
        );

        ecu_chan_reg #(.CNT_W(CNT_W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .hit_i  (edge_hit[g]),
            .clr_i  (clr_i[g]),
            .cnt_i  (cnt_i),
            .cap_o  (cap_q[g]),
            .flag_o (flag_o[g])
        );
    end

    assign rd_data_o = cap_q[rd_addr_i];
    assign irq_o     = |(flag_o & irq_en_i);

endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int CNT_W = 32,
    parameter int NCH   = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CNT_W-1:0]      cnt_i,
    input logic [2*NCH-1:0]      ctrl_i,
    input logic [NCH-1:0]        clr_i,
    input logic [NCH-1:0]        flag_o,
    input logic [NCH-1:0]        edge_hit,
    input logic [NCH-1:0][CNT_W-1:0] cap_q
);
    // R1: reset leaves all flags low
    a_r1_reset_flags: assert property (@(posedge clk) $past(rst) |-> (flag_o == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R2: a detected edge stores the counter of that cycle
        a_r2_capture_value: assert property (@(posedge clk) disable iff (rst)
            edge_hit[g] |=> (cap_q[g] == $past(cnt_i)));
        // R7: off mode keeps the register untouched
        a_r7_off_holds: assert property (@(posedge clk) disable iff (rst)
            (ctrl_i[2*g +: 2] == 2'b00) |=> $stable(cap_q[g]));
        // R8: flag stays set without a clear
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
        // R9: clear without a coincident edge drops the flag
        a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !edge_hit[g]) |=> !flag_o[g]);
        // R10: an edge sets the flag even against a clear
        a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
            edge_hit[g] |=> flag_o[g]);
    end

endmodule

bind edge_capture_unit edge_capture_unit_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnt_i),
    .ctrl_i   (ctrl_i),
    .clr_i    (clr_i),
    .flag_o   (flag_o),
    .edge_hit (edge_hit),
    .cap_q    (cap_q)
);

// File: tb/edge_capture_unit_tb.sv
`timescale 1ns/1ps
module edge_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cnt;
    logic [1:0]  pin = 2'b00;
    logic [3:0]  ctrl = 4'b0000;
    logic [1:0]  clr = 2'b00;
    logic [1:0]  irq_en = 2'b00;
    logic [0:0]  rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  flag_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    int npos = 0;
    bit done = 0;

    typedef struct {
        int          ch;
        int          due;
        logic [31:0] cap;
        logic        flag;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [31:0] exp_cap[2];
    logic        exp_flag[2];
    logic [1:0]  mode[2];
    logic        level[2];

    always #2 clk = ~clk;

    edge_capture_unit u_dut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .pin_i(pin), .ctrl_i(ctrl),
        .clr_i(clr), .irq_en_i(irq_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .flag_o(flag_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        npos <= npos + 1;
        cnt  <= rst ? 32'h100 : cnt + 32'd7;
    end

    // Monitor: pops due items, reads the register through the port (R12) and compares.
    always @(negedge clk) begin
        item_t it;
        while (sb.size() > 0 && sb[0].due <= npos) begin
            it = sb.pop_front();
            rd_addr = it.ch[0];
            #0.2;
            total++;
            if (rd_data !== it.cap || flag_o[it.ch] !== it.flag) begin
                bad++;
                $display("FAIL %s/R12 ch%0d: cap=%h flag=%b expected cap=%h flag=%b",
                         it.tag, it.ch, rd_data, flag_o[it.ch], it.cap, it.flag);
            end
        end
    end

    function automatic logic fires(input logic [1:0] m, input logic now_l, input logic old_l);
        case (m)
            2'd1: return now_l & ~old_l;
            2'd2: return ~now_l & old_l;
            2'd3: return now_l ^ old_l;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input int ch, input int due, input string tag);
        item_t it;
        it.ch = ch; it.due = due; it.cap = exp_cap[ch]; it.flag = exp_flag[ch]; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic set_ctrl(input logic [3:0] v);
        @(negedge clk);
        ctrl = v;
        mode[0] = v[1:0];
        mode[1] = v[3:2];
    endtask

    // Driver: changes pins, predicts the result three edges later.
    task automatic edge_step(input logic [1:0] mask, input logic [1:0] lvl,
                             input bit clr_mid, input string tag);
        logic [31:0] c0;
        int d;
        @(negedge clk);
        c0 = cnt;
        d = npos + 3;
        for (int ch = 0; ch < 2; ch++) begin
            if (mask[ch]) begin
                if (fires(mode[ch], lvl[ch], level[ch])) begin
                    exp_cap[ch]  = c0 + 32'd14;
                    exp_flag[ch] = 1'b1;
                end else if (clr_mid) begin
                    exp_flag[ch] = 1'b0;
                end
                level[ch] = lvl[ch];
                pin[ch]   = lvl[ch];
                push(ch, d, tag);
            end
        end
        if (clr_mid) begin
            repeat (2) @(negedge clk);
            clr = mask;
            @(negedge clk);
            clr = 2'b00;
        end else begin
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic clear_flags(input logic [1:0] mask, input string tag);
        @(negedge clk);
        clr = mask;
        for (int ch = 0; ch < 2; ch++) begin
            if (mask[ch]) exp_flag[ch] = 1'b0;
            push(ch, npos + 1, tag);
        end
        @(negedge clk);
        clr = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_irq(input logic [1:0] en, input string tag);
        logic e;
        @(negedge clk);
        irq_en = en;
        #0.2;
        e = (exp_flag[0] & en[0]) | (exp_flag[1] & en[1]);
        total++;
        if (irq_o !== e) begin
            bad++;
            $display("FAIL %s: irq=%b expected %b", tag, irq_o, e);
        end
    endtask

    initial begin
        for (int ch = 0; ch < 2; ch++) begin
            exp_cap[ch] = '0; exp_flag[ch] = 1'b0; mode[ch] = 2'd0; level[ch] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        push(0, npos + 1, "R1");
        push(1, npos + 1, "R1");
        check_irq(2'b11, "R1");
        repeat (2) @(negedge clk);

        set_ctrl(4'b1001);                        // R3: ch0 rising, ch1 falling
        edge_step(2'b01, 2'b01, 0, "R2");         // ch0 rises: capture
        edge_step(2'b01, 2'b00, 0, "R4");         // ch0 falls: ignored
        edge_step(2'b10, 2'b10, 0, "R5");         // ch1 rises: ignored
        edge_step(2'b10, 2'b00, 0, "R5");         // ch1 falls: capture
        check_irq(2'b01, "R11");
        check_irq(2'b00, "R11");
        check_irq(2'b10, "R11");
        clear_flags(2'b00, "R9");
        clear_flags(2'b01, "R9");
        check_irq(2'b01, "R11");
        clear_flags(2'b10, "R9");

        edge_step(2'b01, 2'b01, 0, "R3");         // ch0 capture, flag set
        edge_step(2'b01, 2'b00, 0, "R4");
        edge_step(2'b01, 2'b01, 0, "R8");         // overwrite with flag still set

        set_ctrl(4'b0011);                        // ch0 either edge, ch1 off
        edge_step(2'b01, 2'b00, 0, "R6");
        edge_step(2'b01, 2'b01, 0, "R6");
        edge_step(2'b10, 2'b10, 0, "R7");
        edge_step(2'b10, 2'b00, 0, "R7");

        set_ctrl(4'b1111);
        edge_step(2'b11, 2'b10, 0, "R13");        // both pins change together
        edge_step(2'b01, 2'b00, 1, "R10");        // capture meets clear
        edge_step(2'b11, 2'b01, 1, "R10");
        repeat (4) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule